// File: doc/BRIEF.md
# Floppy Control Latch with Motor Timer

This block holds two eight-bit addressable control latches. Each latch is written one bit at a time: a three-bit select names the bit, a data input supplies the new value and a write enable makes the write happen. Every other bit keeps its value. The latched bits drive plain control pins: terminal count, in-use, drive select, mini-drive select and the memory-map enable. They also drive the ready line that goes to the disk controller. That line is the inverse of its latch bit, and it is reloaded only when the bit takes a new value. A single-cycle change strobe marks each such reload. Writing a one to the reset bit of the second latch gives a one-cycle soft-reset pulse to the controller.

The block also sequences the drive motor. Writing the active-low motor bit of the first latch to zero starts the motor at once. Writing that bit to one arms a retriggerable timeout of a parameterised number of clock cycles; when the timeout runs out, the motor stops. Writing the active-low stop bit of the second latch to zero stops the motor at once. Both the motor-on write and the stop write cancel any pending timeout. A status bit reports the motor line as it stands. All pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure: every write enable is accepted on the edge where it is high.

Top module: `fdc_ctl_latch`

## Requirements
- R1: After reset, every bit of both latches is 0. The ready output is 1, the change strobe and soft-reset pulse are 0, and the motor line is 1 (motor off).
- R2: A write with enable high updates only the selected bit, from the next clock edge on. A cycle with enable low changes nothing. The pin map is: first latch bit 4 → `tc`, bit 5 → `in_use`, bit 7 → `drv_sel`; second latch bit 1 → `mini`, bit 7 → `map_en`.
- R3: `fdc_ready` is the inverse of bit 3 of the first latch. It is reloaded on the clock edge after that bit changes value. `rdy_chg` is high for exactly the one cycle between those two edges. Rewriting the bit with the value it already holds produces no strobe.
- R4: Writing 0 to bit 6 of the first latch drives `motor_off` low on the next edge and cancels any pending timeout.
- R5: Writing 1 to bit 6 of the first latch loads the timeout. Unless it is cancelled, `motor_off` goes high exactly `TMO_CYCLES` edges after the write edge. A further write of 1 restarts the full count.
- R6: Writing 0 to bit 4 of the second latch drives `motor_off` high on the next edge and cancels any pending timeout.
- R7: When a stop write and a motor-on write fall on the same edge, the stop wins. When a motor-on write falls on the edge where the timeout would expire, the motor-on write wins and the motor stays on.
- R8: Each write of 1 to bit 0 of the second latch gives `fdc_srst` high for exactly the cycle after the write edge. Back-to-back writes give back-to-back pulses. Writing 0 to that bit gives no pulse.
- R9: `motor_status` always equals `motor_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_we | input | 1 | First latch write enable |
| a_sel | input | 3 | First latch bit select |
| a_dat | input | 1 | First latch data bit |
| b_we | input | 1 | Second latch write enable |
| b_sel | input | 3 | Second latch bit select |
| b_dat | input | 1 | Second latch data bit |
| fdc_ready | output | 1 | Inverted ready level to controller |
| rdy_chg | output | 1 | One-cycle strobe when ready is reloaded |
| tc | output | 1 | Terminal count |
| in_use | output | 1 | Drive in-use indicator |
| drv_sel | output | 1 | Drive select |
| fdc_srst | output | 1 | Controller soft-reset pulse |
| mini | output | 1 | Mini-drive select |
| map_en | output | 1 | Memory-map enable |
| motor_off | output | 1 | Motor line, 1 = motor off |
| motor_status | output | 1 | Status bit 0, motor line readback |

## Verification
Two motor functions can meet on a single edge. A stop write on the second latch can arrive together with a motor-on write on the first latch; the bench drives both ports in the same cycle and expects the motor to be off afterwards. The timeout can also expire on the same edge as a motor-on write; the bench arms the timeout, counts `TMO_CYCLES` minus one idle cycles, places the motor-on write on the expiry edge, and then expects the motor to stay on through a window longer than the timeout.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam int LATCH_W = 8;
  localparam int SEL_W   = $clog2(LATCH_W);

  // bit positions in the first latch
  localparam logic [SEL_W-1:0] A_RDY     = 3'd3;
  localparam logic [SEL_W-1:0] A_TC      = 3'd4;
  localparam logic [SEL_W-1:0] A_INUSE   = 3'd5;
  localparam logic [SEL_W-1:0] A_MOTOR_N = 3'd6;
  localparam logic [SEL_W-1:0] A_DSEL    = 3'd7;

  // bit positions in the second latch
  localparam logic [SEL_W-1:0] B_SRST    = 3'd0;
  localparam logic [SEL_W-1:0] B_MINI    = 3'd1;
  localparam logic [SEL_W-1:0] B_STOP_N  = 3'd4;
  localparam logic [SEL_W-1:0] B_MAP_EN  = 3'd7;

  typedef struct packed {
    logic             we;
    logic [SEL_W-1:0] sel;
    logic             dat;
  } latch_wr_t;
endpackage

// File: rtl/fcl_addr_latch.sv
module fcl_addr_latch #(
  parameter int WIDTH = 8,
  localparam int SW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SW-1:0]    sel,
  input  logic             dat,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] hit
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign hit[i] = we && (sel == SW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (hit[i]) q[i] <= dat;
    end
  end
endmodule

// File: rtl/fcl_ready_track.sv
module fcl_ready_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic ready_n_o,
  output logic chg_o
);
  logic seen;

  assign chg_o = lvl ^ seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      ready_n_o <= 1'b1;
    end else if (chg_o) begin
      seen      <= lvl;
      ready_n_o <= ~lvl;
    end
  end
endmodule

// File: rtl/fcl_motor_seq.sv
module fcl_motor_seq #(
  parameter int TMO_CYCLES = 1000,
  localparam int CW        = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic arm_req,
  input  logic stop_req,
  output logic motor_off_o
);
  logic          armed;
  logic [CW-1:0] cnt;

  // priority: stop, motor on, arm, expiry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      motor_off_o <= 1'b1;
      armed       <= 1'b0;
      cnt         <= '0;
    end else if (stop_req) begin
      motor_off_o <= 1'b1;
      armed       <= 1'b0;
    end else if (on_req) begin
      motor_off_o <= 1'b0;
      armed       <= 1'b0;
    end else if (arm_req) begin
      armed       <= 1'b1;
      cnt         <= CW'(TMO_CYCLES);
    end else if (armed) begin
      if (cnt == CW'(1)) begin
        motor_off_o <= 1'b1;
        armed       <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/fdc_ctl_latch.sv
module fdc_ctl_latch
  import fcl_pkg::*;
#(
  parameter int TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_we,
  input  logic [2:0] a_sel,
  input  logic       a_dat,
  input  logic       b_we,
  input  logic [2:0] b_sel,
  input  logic       b_dat,
  output logic       fdc_ready,
  output logic       rdy_chg,
  output logic       tc,
  output logic       in_use,
  output logic       drv_sel,
  output logic       fdc_srst,
  output logic       mini,
  output logic       map_en,
  output logic       motor_off,
  output logic       motor_status
);
  latch_wr_t          wr_a, wr_b;
  logic [LATCH_W-1:0] qa, qb, hit_a, hit_b;
  logic               srst_q;
  logic               unused_bits;

  assign wr_a = '{we: a_we, sel: a_sel, dat: a_dat};
  assign wr_b = '{we: b_we, sel: b_sel, dat: b_dat};

  fcl_addr_latch #(.WIDTH(LATCH_W)) u_lat_a (
    .clk(clk), .rst_n(rst_n), .we(wr_a.we), .sel(wr_a.sel), .dat(wr_a.dat),
    .q(qa), .hit(hit_a)
  );

  fcl_addr_latch #(.WIDTH(LATCH_W)) u_lat_b (
    .clk(clk), .rst_n(rst_n), .we(wr_b.we), .sel(wr_b.sel), .dat(wr_b.dat),
    .q(qb), .hit(hit_b)
  );

  fcl_ready_track u_rdy (
    .clk(clk), .rst_n(rst_n), .lvl(qa[A_RDY]),
    .ready_n_o(fdc_ready), .chg_o(rdy_chg)
  );

  fcl_motor_seq #(.TMO_CYCLES(TMO_CYCLES)) u_mot (
    .clk(clk), .rst_n(rst_n),
    .on_req  (hit_a[A_MOTOR_N] & ~wr_a.dat),
    .arm_req (hit_a[A_MOTOR_N] &  wr_a.dat),
    .stop_req(hit_b[B_STOP_N]  & ~wr_b.dat),
    .motor_off_o(motor_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= hit_b[B_SRST] & wr_b.dat;
  end

  assign fdc_srst     = srst_q;
  assign tc           = qa[A_TC];
  assign in_use       = qa[A_INUSE];
  assign drv_sel      = qa[A_DSEL];
  assign mini         = qb[B_MINI];
  assign map_en       = qb[B_MAP_EN];
  assign motor_status = motor_off;

  assign unused_bits = ^{qa[2:0], qa[A_MOTOR_N], qb[6:2], qb[B_SRST],
                         hit_a[5:0], hit_a[7], hit_b[7:5], hit_b[3:1]};
endmodule

// File: rtl/fdc_ctl_latch_chk.sv
module fdc_ctl_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_we,
  input logic [2:0] a_sel,
  input logic       a_dat,
  input logic       b_we,
  input logic [2:0] b_sel,
  input logic       b_dat,
  input logic       fdc_ready,
  input logic       rdy_chg,
  input logic       fdc_srst,
  input logic       motor_off,
  input logic       motor_status
);
  logic on_w, stop_w, srst_w;
  assign on_w   = a_we && a_sel == 3'd6 && !a_dat;
  assign stop_w = b_we && b_sel == 3'd4 && !b_dat;
  assign srst_w = b_we && b_sel == 3'd0 && b_dat;

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_chg |=> $stable(fdc_ready)); // R3
  AST_RDY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_chg |=> (fdc_ready != $past(fdc_ready))); // R3
  AST_MOTOR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (on_w && !stop_w) |=> !motor_off); // R4
  AST_MOTOR_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(motor_off) |-> $past(on_w)); // R4
  AST_MOTOR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> motor_off); // R6
  AST_SRST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> fdc_srst); // R8
  AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_srst |-> $past(srst_w)); // R8
  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    motor_status == motor_off); // R9
endmodule

bind fdc_ctl_latch fdc_ctl_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_sel(a_sel), .a_dat(a_dat),
  .b_we(b_we), .b_sel(b_sel), .b_dat(b_dat), .fdc_ready(fdc_ready),
  .rdy_chg(rdy_chg), .fdc_srst(fdc_srst), .motor_off(motor_off),
  .motor_status(motor_status)
);

// File: tb/fdc_ctl_latch_tb_top.sv
module fdc_ctl_latch_tb_top;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_we = 1'b0, a_dat = 1'b0, b_we = 1'b0, b_dat = 1'b0;
  logic [2:0] a_sel = '0, b_sel = '0;
  logic fdc_ready, rdy_chg, tc, in_use, drv_sel, fdc_srst, mini, map_en;
  logic motor_off, motor_status;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  fdc_ctl_latch #(.TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_sel(a_sel), .a_dat(a_dat),
    .b_we(b_we), .b_sel(b_sel), .b_dat(b_dat), .fdc_ready(fdc_ready),
    .rdy_chg(rdy_chg), .tc(tc), .in_use(in_use), .drv_sel(drv_sel),
    .fdc_srst(fdc_srst), .mini(mini), .map_en(map_en),
    .motor_off(motor_off), .motor_status(motor_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_a(input logic [2:0] s, input logic d);
    a_we = 1'b1; a_sel = s; a_dat = d;
    @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic wr_b(input logic [2:0] s, input logic d);
    b_we = 1'b1; b_sel = s; b_dat = d;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 tc/inuse/dsel/mini/mapen", {tc, in_use, drv_sel, mini, map_en}, 5'b0);
    check("R1 ready", fdc_ready, 1);
    check("R1 chg/srst", {rdy_chg, fdc_srst}, 2'b0);
    check("R1 motor_off", motor_off, 1);
    check("R9 status at reset", motor_status, 1);
  endtask

  task automatic t_latch_bits;
    wr_a(3'd4, 1'b1);
    check("R2 tc set", {tc, in_use, drv_sel}, 3'b100);
    wr_a(3'd7, 1'b1);
    check("R2 dsel set, tc held", {tc, in_use, drv_sel}, 3'b101);
    wr_a(3'd5, 1'b1);
    wr_a(3'd4, 1'b0);
    check("R2 tc clear", {tc, in_use, drv_sel}, 3'b011);
    wr_b(3'd1, 1'b1);
    wr_b(3'd7, 1'b1);
    check("R2 mini/mapen", {mini, map_en}, 2'b11);
    a_sel = 3'd4; a_dat = 1'b1; b_sel = 3'd7; b_dat = 1'b0;
    idle(2);
    check("R2 no write without enable", {tc, map_en}, 2'b01);
    wr_b(3'd7, 1'b0);
    check("R2 mapen clear", {mini, map_en}, 2'b10);
  endtask

  task automatic t_ready;
    wr_a(3'd3, 1'b1);
    check("R3 strobe after change", rdy_chg, 1);
    check("R3 ready not yet", fdc_ready, 1);
    idle(1);
    check("R3 strobe one cycle", rdy_chg, 0);
    check("R3 ready inverted", fdc_ready, 0);
    wr_a(3'd3, 1'b1);
    check("R3 same value no strobe", rdy_chg, 0);
    wr_a(3'd3, 1'b0);
    check("R3 strobe on clear", rdy_chg, 1);
    idle(1);
    check("R3 ready back high", fdc_ready, 1);
  endtask

  task automatic t_srst;
    wr_b(3'd0, 1'b1);
    check("R8 pulse", fdc_srst, 1);
    idle(1);
    check("R8 pulse width", fdc_srst, 0);
    b_we = 1'b1; b_sel = 3'd0; b_dat = 1'b1;
    idle(1);
    check("R8 back-to-back first", fdc_srst, 1);
    idle(1);
    b_we = 1'b0;
    check("R8 back-to-back second", fdc_srst, 1);
    idle(1);
    check("R8 ends", fdc_srst, 0);
    wr_b(3'd0, 1'b0);
    check("R8 write 0 no pulse", fdc_srst, 0);
  endtask

  task automatic t_on_stop;
    wr_a(3'd6, 1'b0);
    check("R4 motor on", motor_off, 0);
    check("R9 status on", motor_status, 0);
    wr_b(3'd4, 1'b0);
    check("R6 motor stopped", motor_off, 1);
    check("R9 status off", motor_status, 1);
    wr_b(3'd4, 1'b1);
    check("R6 stop release no effect", motor_off, 1);
  endtask

  task automatic t_timer;
    wr_a(3'd6, 1'b0);
    wr_a(3'd6, 1'b1);
    idle(TMO - 1);
    check("R5 still on before timeout", motor_off, 0);
    idle(1);
    check("R5 off at timeout", motor_off, 1);
    // retrigger
    wr_a(3'd6, 1'b0);
    wr_a(3'd6, 1'b1);
    idle(4);
    wr_a(3'd6, 1'b1);
    idle(TMO - 1);
    check("R5 retrigger holds", motor_off, 0);
    idle(1);
    check("R5 retrigger expiry", motor_off, 1);
    // on-write cancels timeout
    wr_a(3'd6, 1'b0);
    wr_a(3'd6, 1'b1);
    idle(3);
    wr_a(3'd6, 1'b0);
    idle(TMO + 2);
    check("R4 on cancels timeout", motor_off, 0);
  endtask

  task automatic t_collide;
    a_we = 1'b1; a_sel = 3'd6; a_dat = 1'b0;
    b_we = 1'b1; b_sel = 3'd4; b_dat = 1'b0;
    idle(1);
    a_we = 1'b0; b_we = 1'b0;
    check("R7 stop beats on", motor_off, 1);
    wr_a(3'd6, 1'b0);
    wr_a(3'd6, 1'b1);
    idle(TMO - 1);
    wr_a(3'd6, 1'b0);
    check("R7 on beats expiry", motor_off, 0);
    idle(TMO + 2);
    check("R7 timer cancelled", motor_off, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latch_bits();
    t_ready();
    t_srst();
    t_on_stop();
    t_timer();
    t_collide();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule